// File: doc/BRIEF.md
# Dual-Mode Serial Register Access Port

This block is a slave serial front end that gives byte access to a 128-location register space. The low 32 locations are clock, alarm and control registers. The upper 96 are general RAM. Every transaction opens with an address byte while chip enable is high, followed by any number of data bytes. The location pointer steps after each data byte and wraps inside its own region, so a single burst can sweep the clock bank or the RAM bank.

Two serial formats are served, selected by a static mode pin:

- **Four-wire SPI.** There are separate data in and data out lines and bytes travel MSB first. The idle level of SCLK is learned when chip enable rises, so either clock polarity works.
- **Three-wire.** The data lines are tied together externally and bytes travel LSB first. Data is taken on the rising edge and driven on the falling edge.

All serial inputs are oversampled by the system clock. SCLK must therefore stay at each level for at least five system clock cycles.

The time registers (the first seven locations) are supplied by an external timekeeper on `time_i`. They are frozen into a copy when a read transaction starts. Accepted writes are reported on a one-cycle strobe, so that timekeeper can load new time values. A write-protect bit in the control register blocks every write except the one that clears it.

Top module: `sreg_port`

## Requirements
- R1: The first byte after chip enable rises is the address byte. Bit 7 = 0 selects read and bit 7 = 1 selects write. Bits 6..0 give the location, so read codes are 00h–7Fh and write codes are 80h–FFh.
- R2: SPI mode (`mode_spi_i` = 1):
  - The SCLK level seen when chip enable rises is the idle level.
  - `sdi_i` is captured on the edge that returns SCLK to idle.
  - `sdo_o` changes on the edge that leaves idle.
  - Bytes are MSB first.
- R3: In three-wire mode (`mode_spi_i` = 0), bytes are LSB first, input bits are captured on rising SCLK and read bits are driven after falling SCLK.
- R4: `sdo_oe_o` is low out of reset, during the address byte and in write transactions. It rises only when the first read bit is driven. It falls within three cycles once chip enable is low.
- R5: In the clock region the pointer steps by one after every data byte and wraps from 1Fh to 00h. Seen as command codes, this is 1Fh→00h for reads and 9Fh→80h for writes.
- R6: In the RAM region the pointer wraps from 7Fh to 20h. Seen as command codes, this is 7Fh→20h for reads and FFh→A0h for writes.
- R7: A write byte cut off by chip enable falling before its eighth bit leaves storage unchanged and produces no write strobe.
- R8: Bit 6 of the control register (location 0Fh) is write protect, and the register resets to 40h. While it is 1, all writes are ignored except that a write to 0Fh copies data bit 6 into it. The other control bits are kept.
- R9: Locations 12h–1Fh read as 00h.
- R10: Locations 00h–06h return the bytes of `time_i` (byte k at bits 8k+7..8k) as sampled when the read address byte completed. They stay fixed for the rest of that burst.
- R11: Chip enable low ends the transaction, and the next byte after chip enable rises again is treated as an address.
- R12: Each accepted write pulses `wr_stb_o` for one cycle, carrying the location on `wr_addr_o` and the byte on `wr_data_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| mode_spi_i | input | 1 | 1 = four-wire SPI, 0 = three-wire |
| ce_i | input | 1 | Chip enable, high during a transaction |
| sclk_i | input | 1 | Serial clock from the master |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Output enable for sdo_o (low = high impedance) |
| time_i | input | 56 | Live time bytes from the timekeeper, location k in byte k |
| ctrl_o | output | 8 | Current control register |
| wr_stb_o | output | 1 | One-cycle pulse per accepted write |
| wr_addr_o | output | 7 | Location of the accepted write |
| wr_data_o | output | 8 | Data of the accepted write |

## Verification
The hardest situations to reach are the pointer wraps. They need a burst long enough to cross a region end, so the bench writes 96 bytes starting at 70h, which must fold from FFh back to A0h to cover the RAM once. It then reads 100 bytes from 7Ch, so the read has to fold from 7Fh to 20h and check every byte.

The clock-bank write wrap is only visible through the write strobe. The bench therefore logs strobe locations and checks that the one after 1Fh is 00h.

Snapshot freezing needs `time_i` to change inside a burst read. The bench changes it after the first data byte and expects the old values. The whole sequence repeats for SPI with both idle levels and for three-wire.

// File: rtl/sreg_port_pkg.sv
package sreg_port_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned BIT_IDX_W = $clog2(BYTE_W);

  typedef enum logic {
    PH_ADDR = 1'b0,
    PH_DATA = 1'b1
  } phase_e;
endpackage

// File: rtl/sreg_port_sync.sv
// Oversamples chip enable, serial clock and data; classifies serial clock
// edges into capture and drive roles from the idle level learned at select.
module sreg_port_sync #(
  parameter int unsigned SYNC_N = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic spi_mode,
  input  logic ce_i,
  input  logic sclk_i,
  input  logic sdi_i,
  output logic ce_s,
  output logic latch_p,
  output logic shift_p,
  output logic din
);
  logic [SYNC_N-1:0] ce_q, sk_q, sd_q;
  logic ce_d, sk_d, idle_hi;
  logic sk_s, active, rise, fall;

  assign ce_s = ce_q[SYNC_N-1];
  assign sk_s = sk_q[SYNC_N-1];
  assign din  = sd_q[SYNC_N-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      ce_q    <= '0;
      sk_q    <= '0;
      sd_q    <= '0;
      ce_d    <= 1'b0;
      sk_d    <= 1'b0;
      idle_hi <= 1'b1;
    end else begin
      ce_q <= {ce_q[SYNC_N-2:0], ce_i};
      sk_q <= {sk_q[SYNC_N-2:0], sclk_i};
      sd_q <= {sd_q[SYNC_N-2:0], sdi_i};
      ce_d <= ce_s;
      sk_d <= sk_s;
      // three-wire behaves like an idle-high SPI clock: capture on rise
      if (ce_s && !ce_d) idle_hi <= spi_mode ? sk_s : 1'b1;
    end
  end

  assign active  = ce_s & ce_d;
  assign rise    = sk_s & ~sk_d;
  assign fall    = ~sk_s & sk_d;
  assign latch_p = active & (idle_hi ? rise : fall);
  assign shift_p = active & (idle_hi ? fall : rise);
endmodule

// File: rtl/sreg_port_xfer.sv
// Byte assembly, address phase, location pointer and read bit serializer.
module sreg_port_xfer
  import sreg_port_pkg::*;
#(
  parameter int unsigned ADDR_W   = 7,
  parameter int unsigned CLK_TOP  = 'h1F,
  parameter int unsigned RAM_BASE = 'h20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_mode,
  input  logic              ce_s,
  input  logic              latch_p,
  input  logic              shift_p,
  input  logic              din,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic [ADDR_W-1:0] ptr_o,
  output logic              snap_p,
  output logic              adv_p,
  output logic              wr_p,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              sdo,
  output logic              sdo_oe
);
  localparam int unsigned RAM_TOP = (1 << ADDR_W) - 1;

  phase_e               phase;
  logic                 is_rd;
  logic [BIT_IDX_W-1:0] bcnt;
  logic [BYTE_W-1:0]    sh, byte_nx;
  logic [ADDR_W-1:0]    ptr;
  logic                 last;
  logic [BIT_IDX_W-1:0] out_idx;

  function automatic logic [ADDR_W-1:0] step_ptr(input logic [ADDR_W-1:0] p);
    if (p == ADDR_W'(CLK_TOP))      return '0;
    else if (p == ADDR_W'(RAM_TOP)) return ADDR_W'(RAM_BASE);
    else                            return ADDR_W'(p + 1'b1);
  endfunction

  assign byte_nx = spi_mode ? {sh[BYTE_W-2:0], din} : {din, sh[BYTE_W-1:1]};
  assign last    = (bcnt == BIT_IDX_W'(BYTE_W - 1));
  assign out_idx = spi_mode ? BIT_IDX_W'(BYTE_W - 1) - bcnt : bcnt;
  assign ptr_o   = ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_ADDR;
      is_rd   <= 1'b0;
      bcnt    <= '0;
      sh      <= '0;
      ptr     <= '0;
      snap_p  <= 1'b0;
      adv_p   <= 1'b0;
      wr_p    <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      sdo     <= 1'b0;
      sdo_oe  <= 1'b0;
    end else begin
      snap_p <= 1'b0;
      adv_p  <= 1'b0;
      wr_p   <= 1'b0;
      if (!ce_s) begin
        phase  <= PH_ADDR;
        bcnt   <= '0;
        sdo_oe <= 1'b0;
      end else begin
        if (latch_p) begin
          sh   <= byte_nx;
          bcnt <= bcnt + 1'b1;
          if (last) begin
            if (phase == PH_ADDR) begin
              phase  <= PH_DATA;
              ptr    <= byte_nx[ADDR_W-1:0];
              is_rd  <= ~byte_nx[BYTE_W-1];
              snap_p <= ~byte_nx[BYTE_W-1];
            end else begin
              adv_p <= 1'b1;
              ptr   <= step_ptr(ptr);
              if (!is_rd) begin
                wr_p    <= 1'b1;
                wr_addr <= ptr;
                wr_data <= byte_nx;
              end
            end
          end
        end
        if (shift_p && phase == PH_DATA && is_rd) begin
          sdo    <= tx_byte[out_idx];
          sdo_oe <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sreg_port_regs.sv
// Storage array, control register with write protect, time snapshot and
// read-side multiplexer.
module sreg_port_regs
  import sreg_port_pkg::*;
#(
  parameter int unsigned ADDR_W    = 7,
  parameter int unsigned NTIME     = 7,
  parameter int unsigned CTRL_ADDR = 'h0F,
  parameter int unsigned RSV_LO    = 'h12,
  parameter int unsigned RSV_HI    = 'h1F,
  parameter int unsigned WP_BIT    = 6,
  parameter logic [7:0]  CTRL_RST  = 8'h40
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ADDR_W-1:0]       ptr,
  input  logic                    snap_p,
  input  logic [NTIME*BYTE_W-1:0] time_i,
  input  logic                    wr_p,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [BYTE_W-1:0]       wr_data,
  output logic [BYTE_W-1:0]       tx_byte,
  output logic [BYTE_W-1:0]       ctrl_o,
  output logic                    wr_stb_o,
  output logic [ADDR_W-1:0]       wr_addr_o,
  output logic [BYTE_W-1:0]       wr_data_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [BYTE_W-1:0]       mem [DEPTH];
  logic [BYTE_W-1:0]       rd_q;
  logic [ADDR_W-1:0]       rd_addr_q;
  logic [NTIME*BYTE_W-1:0] snap_q;
  logic [BYTE_W-1:0]       ctrl;
  logic                    wp, to_ctrl, mem_we;

  assign wp      = ctrl[WP_BIT];
  assign to_ctrl = (wr_addr == ADDR_W'(CTRL_ADDR));
  assign mem_we  = wr_p & ~wp & ~to_ctrl;
  assign ctrl_o  = ctrl;

  // plain array: synchronous write and registered read, no reset
  always_ff @(posedge clk) begin
    if (mem_we) mem[wr_addr] <= wr_data;
    rd_q <= mem[ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_addr_q <= '0;
      snap_q    <= '0;
      ctrl      <= CTRL_RST;
      wr_stb_o  <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      rd_addr_q <= ptr;
      if (snap_p) snap_q <= time_i;
      if (wr_p && to_ctrl) begin
        if (wp) ctrl[WP_BIT] <= wr_data[WP_BIT];
        else    ctrl         <= wr_data;
      end
      wr_stb_o  <= wr_p & ~wp;
      wr_addr_o <= wr_addr;
      wr_data_o <= wr_data;
    end
  end

  always_comb begin
    tx_byte = rd_q;
    if (rd_addr_q == ADDR_W'(CTRL_ADDR)) tx_byte = ctrl;
    if (rd_addr_q >= ADDR_W'(RSV_LO) && rd_addr_q <= ADDR_W'(RSV_HI)) tx_byte = '0;
    for (int i = 0; i < NTIME; i++) begin
      if (rd_addr_q == ADDR_W'(i)) tx_byte = snap_q[i*BYTE_W +: BYTE_W];
    end
  end
endmodule

// File: rtl/sreg_port.sv
module sreg_port
  import sreg_port_pkg::*;
#(
  parameter int unsigned ADDR_W    = 7,
  parameter int unsigned NTIME     = 7,
  parameter int unsigned CLK_TOP   = 'h1F,
  parameter int unsigned RAM_BASE  = 'h20,
  parameter int unsigned CTRL_ADDR = 'h0F,
  parameter int unsigned RSV_LO    = 'h12,
  parameter int unsigned WP_BIT    = 6,
  parameter logic [7:0]  CTRL_RST  = 8'h40,
  parameter int unsigned SYNC_N    = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    mode_spi_i,
  input  logic                    ce_i,
  input  logic                    sclk_i,
  input  logic                    sdi_i,
  output logic                    sdo_o,
  output logic                    sdo_oe_o,
  input  logic [NTIME*BYTE_W-1:0] time_i,
  output logic [BYTE_W-1:0]       ctrl_o,
  output logic                    wr_stb_o,
  output logic [ADDR_W-1:0]       wr_addr_o,
  output logic [BYTE_W-1:0]       wr_data_o
);
  logic              ce_s, latch_p, shift_p, din;
  logic [ADDR_W-1:0] ptr, wr_addr;
  logic              snap_p, adv_p, wr_p;
  logic [BYTE_W-1:0] wr_data, tx_byte;

  sreg_port_sync #(.SYNC_N(SYNC_N)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .spi_mode (mode_spi_i),
    .ce_i     (ce_i),
    .sclk_i   (sclk_i),
    .sdi_i    (sdi_i),
    .ce_s     (ce_s),
    .latch_p  (latch_p),
    .shift_p  (shift_p),
    .din      (din)
  );

  sreg_port_xfer #(
    .ADDR_W   (ADDR_W),
    .CLK_TOP  (CLK_TOP),
    .RAM_BASE (RAM_BASE)
  ) u_xfer (
    .clk      (clk),
    .rst      (rst),
    .spi_mode (mode_spi_i),
    .ce_s     (ce_s),
    .latch_p  (latch_p),
    .shift_p  (shift_p),
    .din      (din),
    .tx_byte  (tx_byte),
    .ptr_o    (ptr),
    .snap_p   (snap_p),
    .adv_p    (adv_p),
    .wr_p     (wr_p),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .sdo      (sdo_o),
    .sdo_oe   (sdo_oe_o)
  );

  sreg_port_regs #(
    .ADDR_W    (ADDR_W),
    .NTIME     (NTIME),
    .CTRL_ADDR (CTRL_ADDR),
    .RSV_LO    (RSV_LO),
    .RSV_HI    (CLK_TOP),
    .WP_BIT    (WP_BIT),
    .CTRL_RST  (CTRL_RST)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .ptr       (ptr),
    .snap_p    (snap_p),
    .time_i    (time_i),
    .wr_p      (wr_p),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .tx_byte   (tx_byte),
    .ctrl_o    (ctrl_o),
    .wr_stb_o  (wr_stb_o),
    .wr_addr_o (wr_addr_o),
    .wr_data_o (wr_data_o)
  );
endmodule

// File: rtl/sreg_port_chk.sv
module sreg_port_chk #(
  parameter int unsigned ADDR_W   = 7,
  parameter int unsigned CLK_TOP  = 'h1F,
  parameter int unsigned RAM_BASE = 'h20,
  parameter int unsigned WP_BIT   = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              ce_s,
  input logic              shift_p,
  input logic              adv_p,
  input logic [ADDR_W-1:0] ptr,
  input logic [7:0]        ctrl_o,
  input logic              wr_stb_o,
  input logic              sdo_oe_o
);
  localparam int unsigned RAM_TOP = (1 << ADDR_W) - 1;
  localparam logic [7:0] WP_MASK = 8'(1 << WP_BIT);

  // R4
  oe_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !ce_s |=> !sdo_oe_o);

  // R4
  oe_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sdo_oe_o) |-> $past(shift_p));

  // R5
  clk_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (adv_p && $past(ptr) == ADDR_W'(CLK_TOP)) |-> ptr == '0);

  // R6
  ram_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (adv_p && $past(ptr) == ADDR_W'(RAM_TOP)) |-> ptr == ADDR_W'(RAM_BASE));

  // R5
  ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (adv_p && $past(ptr) != ADDR_W'(CLK_TOP) && $past(ptr) != ADDR_W'(RAM_TOP))
      |-> ptr == ADDR_W'($past(ptr) + 1'b1));

  // R8
  wp_block_chk: assert property (@(posedge clk) disable iff (rst)
    wr_stb_o |-> !$past(ctrl_o[WP_BIT]));

  // R8
  wp_ctrl_chk: assert property (@(posedge clk) disable iff (rst)
    $past(ctrl_o[WP_BIT]) |-> ((ctrl_o | WP_MASK) == ($past(ctrl_o) | WP_MASK)));
endmodule

bind sreg_port sreg_port_chk #(
  .ADDR_W   (ADDR_W),
  .CLK_TOP  (CLK_TOP),
  .RAM_BASE (RAM_BASE),
  .WP_BIT   (WP_BIT)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .ce_s     (ce_s),
  .shift_p  (shift_p),
  .adv_p    (adv_p),
  .ptr      (ptr),
  .ctrl_o   (ctrl_o),
  .wr_stb_o (wr_stb_o),
  .sdo_oe_o (sdo_oe_o)
);

// File: tb/sreg_port_tb.sv
module sreg_port_tb;
  localparam int HP = 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        spi = 1'b1;
  logic        ce = 1'b0;
  logic        sclk = 1'b0;
  logic        sdi = 1'b0;
  logic [55:0] time_v = '0;
  logic        sdo_o, sdo_oe_o, wr_stb_o;
  logic [7:0]  ctrl_o, wr_data_o;
  logic [6:0]  wr_addr_o;

  always #2.5 clk = ~clk;

  sreg_port u_dut (
    .clk(clk), .rst(rst), .mode_spi_i(spi), .ce_i(ce), .sclk_i(sclk),
    .sdi_i(sdi), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o), .time_i(time_v),
    .ctrl_o(ctrl_o), .wr_stb_o(wr_stb_o), .wr_addr_o(wr_addr_o),
    .wr_data_o(wr_data_o)
  );

  int ncmp = 0;
  int nfail = 0;
  bit done = 0;
  logic       m_pol = 1'b0;
  logic [7:0] mdl [128];
  logic [7:0] mctrl = 8'h40;
  logic [6:0] log_a [512];
  logic [7:0] log_d [512];
  int nlog = 0;

  always @(negedge clk) begin
    if (!rst && wr_stb_o) begin
      if (nlog < 512) begin
        log_a[nlog] = wr_addr_o;
        log_d[nlog] = wr_data_o;
      end
      nlog++;
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    ncmp++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] nxt(input logic [6:0] a);
    if (a == 7'h1F) return 7'h00;
    if (a == 7'h7F) return 7'h20;
    return a + 7'd1;
  endfunction

  function automatic logic [7:0] exp_rd(input logic [6:0] a, input logic [55:0] tv);
    if (a < 7'd7) return tv[a*8 +: 8];
    if (a == 7'h0F) return mctrl;
    if (a >= 7'h12 && a <= 7'h1F) return 8'h00;
    return mdl[a];
  endfunction

  task automatic hp();
    repeat (HP) @(negedge clk);
  endtask

  task automatic start();
    sclk = spi ? m_pol : 1'b0;
    sdi = 1'b0;
    repeat (3) @(negedge clk);
    ce = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic stop();
    ce = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
    rx = '0;
    for (int i = 0; i < n; i++) begin
      int b = spi ? 7 - i : i;
      sdi = tx[b];
      if (spi) begin
        sclk = ~m_pol; hp(); rx[b] = sdo_o; sclk = m_pol; hp();
      end else begin
        hp(); rx[b] = sdo_o; sclk = 1'b1; hp(); sclk = 1'b0;
      end
    end
  endtask

  task automatic wr_burst(input logic [6:0] a0, input int n, input logic [7:0] d0,
                          input logic [7:0] stp);
    logic [7:0] rx;
    logic [6:0] a = a0;
    start();
    bits({1'b1, a0}, 8, rx);
    for (int k = 0; k < n; k++) begin
      logic [7:0] d = d0 + 8'(k) * stp;
      bits(d, 8, rx);
      if (a == 7'h0F) begin
        if (mctrl[6]) mctrl[6] = d[6];
        else          mctrl = d;
      end else if (!mctrl[6]) begin
        mdl[a] = d;
      end
      a = nxt(a);
    end
    repeat (4) @(negedge clk);
    chk("R4 write keeps sdo_oe low", {7'd0, sdo_oe_o}, 8'h00);
    stop();
  endtask

  task automatic rd_burst(input logic [6:0] a0, input int n, input string req,
                          input bit mid_change);
    logic [7:0]  rx;
    logic [6:0]  a = a0;
    logic [55:0] tv = time_v;
    start();
    bits({1'b0, a0}, 8, rx);
    if (spi) chk("R4 sdo_oe low after address", {7'd0, sdo_oe_o}, 8'h00);
    for (int k = 0; k < n; k++) begin
      bits(8'h00, 8, rx);
      chk(req, rx, exp_rd(a, tv));
      if (k == 0) chk("R4 sdo_oe high in read", {7'd0, sdo_oe_o}, 8'h01);
      if (mid_change && k == 0) time_v = ~time_v;
      a = nxt(a);
    end
    stop();
    chk("R4 sdo_oe low after ce drop", {7'd0, sdo_oe_o}, 8'h00);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: run did not complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nfail);
      $finish;
    end
  end

  initial begin
    logic [7:0] rx;
    int n0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    // reset state
    chk("R4 reset oe", {7'd0, sdo_oe_o}, 8'h00);
    chk("R8 reset ctrl", ctrl_o, 8'h40);
    chk("R12 reset strobe", {7'd0, wr_stb_o}, 8'h00);

    // write protect sequence, SPI idle low
    spi = 1'b1; m_pol = 1'b0;
    wr_burst(7'h20, 1, 8'h11, 8'h00);
    chk("R8 blocked write gives no strobe", 8'(nlog), 8'd0);
    wr_burst(7'h0F, 1, 8'h47, 8'h00);
    chk("R8 WP set keeps other ctrl bits", ctrl_o, 8'h40);
    wr_burst(7'h0F, 1, 8'h05, 8'h00);
    chk("R8 clearing WP only", ctrl_o, 8'h00);
    wr_burst(7'h0F, 1, 8'h03, 8'h00);
    chk("R8 ctrl full write", ctrl_o, 8'h03);
    chk("R12 strobe count", 8'(nlog), 8'd1);
    chk("R12 strobe addr", {1'b0, log_a[0]}, 8'h0F);
    chk("R12 strobe data", log_d[0], 8'h03);
    wr_burst(7'h20, 1, 8'h11, 8'h00);
    rd_burst(7'h20, 1, "R1 single read", 0);
    wr_burst(7'h0F, 1, 8'h43, 8'h00);
    wr_burst(7'h20, 1, 8'hAA, 8'h00);
    rd_burst(7'h20, 1, "R8 write blocked under WP", 0);
    wr_burst(7'h0F, 1, 8'h00, 8'h00);
    chk("R8 WP cleared, low bits kept", ctrl_o, 8'h03);

    for (int md = 0; md < 3; md++) begin
      string tag;
      spi   = (md < 2);
      m_pol = (md == 1);
      tag   = spi ? "R2 SPI" : "R3 three-wire";
      for (int i = 0; i < 7; i++) time_v[i*8 +: 8] = 8'(md * 16 + i * 9 + 1);
      // RAM sweep with wrap on write and on read
      wr_burst(7'h70, 96, 8'(md * 64 + 1), 8'd3);
      rd_burst(7'h7C, 100, {tag, " R6 RAM wrap"}, 0);
      // alarm area and status bytes
      wr_burst(7'h07, 8, 8'(md + 8'h90), 8'd5);
      wr_burst(7'h10, 2, 8'(md + 8'h30), 8'd1);
      // clock bank write wrap seen on strobes
      n0 = nlog;
      wr_burst(7'h1E, 4, 8'h50, 8'd1);
      chk("R5 write wrap addr", {1'b0, log_a[n0+2]}, 8'h00);
      chk("R5 write step addr", {1'b0, log_a[n0+3]}, 8'h01);
      chk("R12 write data", log_d[n0+3], 8'h53);
      // clock bank read wrap, reserved area, snapshot, control
      rd_burst(7'h1D, 22, {tag, " R5 R9 R10 clock bank"}, 0);
      rd_burst(7'h00, 7, "R10 snapshot frozen", 1);
      rd_burst(7'h00, 2, "R10 new snapshot", 0);
      // aborted write, then a fresh transaction
      wr_burst(7'h30, 1, 8'h5A, 8'h00);
      n0 = nlog;
      start();
      bits(8'hB0, 8, rx);
      bits(8'hFF, 5, rx);
      stop();
      chk("R7 abort gives no strobe", 8'(nlog - n0), 8'd0);
      rd_burst(7'h30, 1, "R7 R11 aborted byte discarded", 0);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nfail);
    $finish;
  end
endmodule